// File: doc/BRIEF.md
# Aliased Accumulator Register File

This block is the architectural data register file of an 8-bit-class processor core. It holds four byte accumulators. Byte pairs of these can also be accessed as two 16-bit registers, and the whole set as one 32-bit register. The file also holds four more registers:
- a 16-bit transfer register that survives a hardware reset;
- a pseudo-register that is constant zero;
- a mode byte in which only four bits exist;
- a scratch byte.

The core addresses each port with a 4-bit register code and a 2-bit size. The size selects a byte, a 16-bit or a 32-bit access. The file has `RD_PORTS` combinational read ports and one write port. The write port commits on the rising clock edge. Read data is always 32 bits wide and is zero-extended above the access size. A code and size pair that names no register reads as zero and raises a per-port error flag. A write with such a pair is dropped and raises the write error flag.

Register codes: 0 = A, 1 = B, 2 = E, 3 = F (bytes); 4 = D, 5 = W, 6 = V (16-bit); 7 = ZERO (byte or 16-bit); 8 = MD, 9 = M (bytes); 10 = Q (32-bit). Size codes: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = illegal.

Top module: `acc_regfile`

## Requirements
- R1: Code 5 at 16-bit size is W, made of byte E (code 2) in bits 15:8 and byte F (code 3) in bits 7:0. Bytes A (code 0) and B (code 1) are independent byte registers.
- R2: Code 4 at 16-bit size is D, with A in bits 15:8 and B in bits 7:0. Code 10 at 32-bit size is Q, with D in bits 31:16 and W in bits 15:0.
- R3: While rst_n is low, A, B, E, F, MD and M clear to zero. V (code 6, 16-bit) keeps the value it held before reset; only a write to V changes it.
- R4: Code 7 reads zero at both 8-bit and 16-bit size without error. A write to it changes no register.
- R5: MD (code 8, byte) implements only bits 7, 6, 1 and 0. Bits 5:2 always read zero, and writes to those bits are ignored.
- R6: M (code 9, byte) stores any written byte and returns it on read. Writing M leaves A, B, E and F unchanged.
- R7: A write to D, W or Q updates every byte it covers in the same edge. A byte write leaves the other bytes of D, W and Q unchanged.
- R8: A read in the same cycle as a write to the same register returns the old value. The new value is visible from the cycle after the edge.
- R9: An unassigned code (11 to 15), size 3, or a size that does not match the code reads as zero with that port's rd_err high. A write with such a pair changes nothing and wr_err is high while we is high.
- R10: Read data above the access width is zero (bits 31:8 for byte reads, 31:16 for 16-bit reads).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes commit on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_code | input | RD_PORTS x 4 | Register code per read port |
| rd_size | input | RD_PORTS x 2 | Access size per read port |
| rd_data | output | RD_PORTS x 32 | Zero-extended read data per port |
| rd_err | output | RD_PORTS | Illegal code/size on that read port |
| we | input | 1 | Write enable |
| wr_code | input | 4 | Register code for the write |
| wr_size | input | 2 | Access size for the write |
| wr_data | input | 32 | Write data, right-aligned |
| wr_err | output | 1 | Write requested with an illegal code/size |

## Verification
The bench targets alias overlap: it writes through one view and reads back through every other view. A design with a swapped byte order or a missed alias would return D, W or Q with the wrong bytes. A narrow write that clobbers its neighbours would also show up here.

It pulses reset after loading V, which catches a transfer register wired to the common reset. It writes all ones to the zero register and the mode byte. A design that stores into the zero register, or keeps the unimplemented mode bits, would read back non-zero. It also reads and writes the same register in one cycle, which exposes a write-through bypass. Finally it probes mismatched sizes, which a loose decoder would accept as valid.

// File: rtl/acc_rf_pkg.sv
package acc_rf_pkg;

    typedef enum logic [3:0] {
        RC_A    = 4'd0,
        RC_B    = 4'd1,
        RC_E    = 4'd2,
        RC_F    = 4'd3,
        RC_D    = 4'd4,
        RC_W    = 4'd5,
        RC_V    = 4'd6,
        RC_ZERO = 4'd7,
        RC_MD   = 4'd8,
        RC_M    = 4'd9,
        RC_Q    = 4'd10
    } rf_code_e;

    typedef enum logic [1:0] {
        SZ_8  = 2'd0,
        SZ_16 = 2'd1,
        SZ_32 = 2'd2,
        SZ_BAD = 2'd3
    } rf_size_e;

    typedef struct packed {
        logic [7:0] a;
        logic [7:0] b;
        logic [7:0] e;
        logic [7:0] f;
        logic [7:0] md;
        logic [7:0] m;
    } rf_state_t;

    localparam rf_state_t RF_RESET = '{default: 8'h00};

endpackage

// File: rtl/rf_decode.sv
module rf_decode
    import acc_rf_pkg::*;
(
    input  logic [3:0] code,
    input  logic [1:0] size,
    output rf_code_e   sel,
    output logic       valid
);
    always_comb begin
        sel   = rf_code_e'(code);
        valid = 1'b0;
        case (code)
            RC_A, RC_B, RC_E, RC_F, RC_MD, RC_M:
                valid = (size == SZ_8);
            RC_D, RC_W, RC_V:
                valid = (size == SZ_16);
            RC_ZERO:
                valid = (size == SZ_8) || (size == SZ_16);
            RC_Q:
                valid = (size == SZ_32);
            default:
                valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/rf_read_mux.sv
module rf_read_mux
    import acc_rf_pkg::*;
#(
    parameter int DW = 32
) (
    input  rf_state_t      st,
    input  logic [15:0]    v,
    input  rf_code_e       sel,
    input  logic           valid,
    output logic [DW-1:0]  data,
    output logic           err
);
    always_comb begin
        data = '0;
        err  = !valid;
        if (valid) begin
            case (sel)
                RC_A:    data[7:0]  = st.a;
                RC_B:    data[7:0]  = st.b;
                RC_E:    data[7:0]  = st.e;
                RC_F:    data[7:0]  = st.f;
                RC_D:    data[15:0] = {st.a, st.b};
                RC_W:    data[15:0] = {st.e, st.f};
                RC_V:    data[15:0] = v;
                RC_MD:   data[7:0]  = st.md;
                RC_M:    data[7:0]  = st.m;
                RC_Q:    data[31:0] = {st.a, st.b, st.e, st.f};
                default: data = '0;
            endcase
        end
    end
endmodule

// File: rtl/acc_regfile.sv
module acc_regfile
    import acc_rf_pkg::*;
#(
    parameter int         RD_PORTS = 2,
    parameter logic [7:0] MD_MASK  = 8'hC3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [RD_PORTS-1:0][3:0]   rd_code,
    input  logic [RD_PORTS-1:0][1:0]   rd_size,
    output logic [RD_PORTS-1:0][31:0]  rd_data,
    output logic [RD_PORTS-1:0]        rd_err,
    input  logic                       we,
    input  logic [3:0]                 wr_code,
    input  logic [1:0]                 wr_size,
    input  logic [31:0]                wr_data,
    output logic                       wr_err
);
    localparam int DW = 32;

    rf_state_t   st_q, st_d;
    logic [15:0] v_q, v_d;

    rf_code_e    w_sel;
    logic        w_valid;

    rf_decode u_wdec (
        .code  (wr_code),
        .size  (wr_size),
        .sel   (w_sel),
        .valid (w_valid)
    );

    assign wr_err = we && !w_valid;

    // next-state computation for every stored byte
    always_comb begin
        st_d = st_q;
        v_d  = v_q;
        if (we && w_valid) begin
            case (w_sel)
                RC_A:  st_d.a  = wr_data[7:0];
                RC_B:  st_d.b  = wr_data[7:0];
                RC_E:  st_d.e  = wr_data[7:0];
                RC_F:  st_d.f  = wr_data[7:0];
                RC_D: begin
                    st_d.a = wr_data[15:8];
                    st_d.b = wr_data[7:0];
                end
                RC_W: begin
                    st_d.e = wr_data[15:8];
                    st_d.f = wr_data[7:0];
                end
                RC_Q: begin
                    st_d.a = wr_data[31:24];
                    st_d.b = wr_data[23:16];
                    st_d.e = wr_data[15:8];
                    st_d.f = wr_data[7:0];
                end
                RC_V:  v_d     = wr_data[15:0];
                RC_MD: st_d.md = wr_data[7:0] & MD_MASK;
                RC_M:  st_d.m  = wr_data[7:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RF_RESET;
        else        st_q <= st_d;
    end

    // transfer register has no reset on purpose
    always_ff @(posedge clk) begin
        if (rst_n) v_q <= v_d;
    end

    for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
        rf_code_e r_sel;
        logic     r_valid;

        rf_decode u_rdec (
            .code  (rd_code[p]),
            .size  (rd_size[p]),
            .sel   (r_sel),
            .valid (r_valid)
        );

        rf_read_mux #(.DW(DW)) u_rmux (
            .st    (st_q),
            .v     (v_q),
            .sel   (r_sel),
            .valid (r_valid),
            .data  (rd_data[p]),
            .err   (rd_err[p])
        );
    end
endmodule

// File: rtl/acc_regfile_chk.sv
module acc_regfile_chk #(
    parameter int         RD_PORTS = 2,
    parameter logic [7:0] MD_MASK  = 8'hC3
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [RD_PORTS-1:0][3:0]   rd_code,
    input logic [RD_PORTS-1:0][1:0]   rd_size,
    input logic [RD_PORTS-1:0][31:0]  rd_data,
    input logic [RD_PORTS-1:0]        rd_err,
    input logic                       we,
    input logic [3:0]                 wr_code,
    input logic [1:0]                 wr_size,
    input logic [31:0]                wr_data,
    input logic                       wr_err
);
    for (genvar p = 0; p < RD_PORTS; p++) begin : g_p
        p_zero_reads_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_code[p] == 4'd7) |-> (rd_data[p] == 32'd0));

        p_md_undef_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_code[p] == 4'd8 && rd_size[p] == 2'd0) |-> ((rd_data[p][7:0] & ~MD_MASK) == 8'd0));

        p_err_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
            rd_err[p] |-> (rd_data[p] == 32'd0));

        p_byte_zext_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_size[p] == 2'd0) |-> (rd_data[p][31:8] == 24'd0));

        p_byte_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(we) && $past(wr_code) == 4'd0 && $past(wr_size) == 2'd0
             && rd_code[p] == 4'd0 && rd_size[p] == 2'd0)
            |-> (rd_data[p][7:0] == $past(wr_data[7:0])));
    end

    if (RD_PORTS >= 2) begin : g_pair
        p_q_holds_d_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_code[0] == 4'd10 && rd_size[0] == 2'd2 && rd_code[1] == 4'd4 && rd_size[1] == 2'd1)
            |-> (rd_data[0][31:16] == rd_data[1][15:0]));

        p_w_high_is_e_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_code[0] == 4'd5 && rd_size[0] == 2'd1 && rd_code[1] == 4'd2 && rd_size[1] == 2'd0)
            |-> (rd_data[0][15:8] == rd_data[1][7:0]));
    end

    p_wr_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!we) |-> !wr_err);
endmodule

bind acc_regfile acc_regfile_chk #(.RD_PORTS(RD_PORTS), .MD_MASK(MD_MASK)) u_chk (.*);

// File: tb/acc_regfile_tb.sv
module acc_regfile_tb;
    localparam int NP = 2;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [NP-1:0][3:0]   rd_code = '0;
    logic [NP-1:0][1:0]   rd_size = '0;
    logic [NP-1:0][31:0]  rd_data;
    logic [NP-1:0]        rd_err;
    logic                 we = 1'b0;
    logic [3:0]           wr_code = '0;
    logic [1:0]           wr_size = '0;
    logic [31:0]          wr_data = '0;
    logic                 wr_err;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    acc_regfile #(.RD_PORTS(NP)) u_dut (.*);

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] c, input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        we = 1'b1; wr_code = c; wr_size = s; wr_data = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic expect_rd(input string tag, input logic [3:0] c, input logic [1:0] s,
                             input logic [31:0] exp, input logic exp_err);
        rd_code[0] = c; rd_size[0] = s;
        #1;
        check(tag, rd_data[0], exp);
        check(tag, {31'd0, rd_err[0]}, {31'd0, exp_err});
    endtask

    task automatic pulse_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_reset();
        wr(4'd6, 2'd1, 32'h0000BEEF);
        wr(4'd10, 2'd2, 32'hDEADC0DE);
        wr(4'd8, 2'd0, 32'hFF);
        wr(4'd9, 2'd0, 32'h77);
        pulse_reset();
        @(negedge clk);
        expect_rd("R3 A clear", 4'd0, 2'd0, 0, 0);
        expect_rd("R3 B clear", 4'd1, 2'd0, 0, 0);
        expect_rd("R3 E clear", 4'd2, 2'd0, 0, 0);
        expect_rd("R3 F clear", 4'd3, 2'd0, 0, 0);
        expect_rd("R3 MD clear", 4'd8, 2'd0, 0, 0);
        expect_rd("R3 M clear", 4'd9, 2'd0, 0, 0);
        expect_rd("R3 V kept", 4'd6, 2'd1, 32'hBEEF, 0);
    endtask

    task automatic t_alias();
        wr(4'd10, 2'd2, 32'h11223344);
        @(negedge clk);
        expect_rd("R1 A", 4'd0, 2'd0, 32'h11, 0);
        expect_rd("R1 B", 4'd1, 2'd0, 32'h22, 0);
        expect_rd("R1 E", 4'd2, 2'd0, 32'h33, 0);
        expect_rd("R1 F", 4'd3, 2'd0, 32'h44, 0);
        expect_rd("R2 D", 4'd4, 2'd1, 32'h1122, 0);
        expect_rd("R1 W", 4'd5, 2'd1, 32'h3344, 0);
        wr(4'd2, 2'd0, 32'hFFFFFFAA);
        expect_rd("R7 byte E into Q", 4'd10, 2'd2, 32'h1122AA44, 0);
        wr(4'd5, 2'd1, 32'hFFFF5566);
        expect_rd("R7 W sets E", 4'd2, 2'd0, 32'h55, 0);
        expect_rd("R7 W sets F", 4'd3, 2'd0, 32'h66, 0);
        wr(4'd4, 2'd1, 32'h7788);
        expect_rd("R2 Q after D", 4'd10, 2'd2, 32'h77885566, 0);
        expect_rd("R10 D zext", 4'd4, 2'd1, 32'h7788, 0);
    endtask

    task automatic t_zero_md_m();
        wr(4'd7, 2'd0, 32'hFF);
        wr(4'd7, 2'd1, 32'hFFFF);
        expect_rd("R4 zero byte", 4'd7, 2'd0, 0, 0);
        expect_rd("R4 zero half", 4'd7, 2'd1, 0, 0);
        expect_rd("R4 Q untouched", 4'd10, 2'd2, 32'h77885566, 0);
        wr(4'd8, 2'd0, 32'hFF);
        expect_rd("R5 MD ones", 4'd8, 2'd0, 32'hC3, 0);
        wr(4'd8, 2'd0, 32'h3C);
        expect_rd("R5 MD undef bits", 4'd8, 2'd0, 32'h00, 0);
        wr(4'd9, 2'd0, 32'h9A);
        expect_rd("R6 M", 4'd9, 2'd0, 32'h9A, 0);
        expect_rd("R6 Q untouched", 4'd10, 2'd2, 32'h77885566, 0);
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        we = 1'b1; wr_code = 4'd0; wr_size = 2'd0; wr_data = 32'h5A;
        expect_rd("R8 old value", 4'd0, 2'd0, 32'h77, 0);
        @(negedge clk);
        we = 1'b0;
        expect_rd("R8 new value", 4'd0, 2'd0, 32'h5A, 0);
    endtask

    task automatic t_illegal();
        expect_rd("R9 bad code", 4'd15, 2'd0, 0, 1);
        expect_rd("R9 A at 32", 4'd0, 2'd2, 0, 1);
        expect_rd("R9 size 3", 4'd10, 2'd3, 0, 1);
        expect_rd("R9 V at 8", 4'd6, 2'd0, 0, 1);
        @(negedge clk);
        we = 1'b1; wr_code = 4'd10; wr_size = 2'd1; wr_data = 32'hFFFFFFFF;
        #1;
        check("R9 wr_err", {31'd0, wr_err}, 32'd1);
        @(negedge clk);
        we = 1'b0;
        #1;
        check("R9 wr_err idle", {31'd0, wr_err}, 32'd0);
        expect_rd("R9 Q untouched", 4'd10, 2'd2, 32'h5A885566, 0);
    endtask

    initial begin
        #1_000_000;
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_alias();
        t_zero_md_m();
        t_same_cycle();
        t_illegal();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule